// File: doc/BRIEF.md
# Servo-Error Sampler and PWM Modulator

This block drives an external 8-bit successive-approximation converter that digitizes an amplified, bipolar torque error. It pulses a start-conversion line, waits for the converter's end-of-conversion edge, and then enables the converter's output for one cycle to latch the result. It then turns that offset-binary code into a duty word. Errors below mid-scale mean "no drive" and give duty zero. Errors above mid-scale are doubled, so the positive half of the converter range spans the full duty range.

The duty word controls a left-aligned chop signal whose period is set by a free-running 8-bit up-counter. No triangular carrier is used. The output is high while the counter is below the duty word. A new duty word takes effect only when the counter wraps, so a pulse is never cut short.

If the converter does not answer within twice its nominal conversion time, the block drops the duty to zero, raises a fault flag and starts a fresh conversion. All pins are plain levels or strobes. The converter handshake is the converter's own protocol, and the duty output is a continuously valid level. Neither has a valid/ready pair, so there is no back-pressure anywhere.

Top module: `servo_pwm`

## Requirements
- R1: While reset is held, start-conversion, output-enable, the PWM output, the duty word and the fault flag are all low.
- R2: Each start-conversion pulse lasts exactly START_LEN clock cycles (at least 2). No new pulse begins until the previous conversion has either been latched or has timed out.
- R3: Output-enable is high for exactly one cycle: the cycle right after the end-of-conversion input is first seen high. The data input is latched at the end of that cycle. Exactly one latch happens per end-of-conversion rising edge.
- R4: The latched code maps to duty as follows. Codes 00h to 80h give 00h. Codes 81h to FEh give 2 × (code − 80h). Code FFh gives FFh.
- R5: The PWM period is 256 clock cycles. In every period the output is high for exactly `duty` cycles, starting at the first cycle of the period.
- R6: A duty word of FFh holds the output high through every cycle. A duty word of 00h holds it low.
- R7: The duty word and the PWM pattern change only on the first cycle of a period, that is, when the counter wraps from FFh to 00h.
- R8: If no end-of-conversion rising edge is seen within 2 × CONV_CYCLES cycles of the start pulse, the fault flag rises. The duty word becomes 00h at the next wrap, and a new conversion is started.
- R9: The fault flag clears when a later conversion completes normally, and the duty then follows that result again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_start | output | 1 | Start-conversion pulse to the converter |
| adc_eoc | input | 1 | End-of-conversion from the converter; its rising edge matters |
| adc_oe | output | 1 | Converter output enable; high during the latch cycle |
| adc_data | input | 8 | Offset-binary conversion result |
| pwm_out | output | 1 | Left-aligned chop signal |
| duty | output | 8 | Duty word currently in force |
| fault | output | 1 | Conversion timeout flag |

## Verification
A wrong sampler state shows at the pins within one conversion. It appears as a start pulse of the wrong length, an output-enable not tied to the end-of-conversion edge, or a second start issued while a conversion is still pending. A wrong mapping or a wrong load moment shows within one 256-cycle period, as a wrong duty word or a wrong count of high cycles. A duty change that is not aligned to the period grid also shows there. A broken timeout shows within 2 × CONV_CYCLES plus one period, as the fault flag or the zero duty failing to appear.

// File: rtl/servo_pwm_pkg.sv
package servo_pwm_pkg;
  typedef enum logic [1:0] {
    SMP_IDLE  = 2'd0,
    SMP_START = 2'd1,
    SMP_WAIT  = 2'd2,
    SMP_LATCH = 2'd3
  } smp_state_t;
endpackage

// File: rtl/err_sampler.sv
module err_sampler
  import servo_pwm_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int START_LEN   = 2,
  parameter int CONV_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              adc_start,
  input  logic              adc_eoc,
  output logic              adc_oe,
  input  logic [DATA_W-1:0] adc_data,
  output logic              upd_valid,
  output logic [DATA_W-1:0] upd_duty,
  output logic              fault
);
  localparam int TMO = 2 * CONV_CYCLES;
  localparam int TW  = $clog2(TMO + 1);
  localparam logic [DATA_W-1:0] MID  = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] FULL = '1;

  smp_state_t        state;
  logic [TW-1:0]     tcnt;
  logic              eoc_q;
  logic              eoc_rise;
  logic [DATA_W:0]   dbl;
  logic [DATA_W-1:0] mapped;

  assign eoc_rise  = adc_eoc & ~eoc_q;
  assign adc_start = (state == SMP_START);
  assign adc_oe    = (state == SMP_LATCH);

  // offset-binary error to duty: negative saturates to zero, positive doubled
  always_comb begin
    dbl = {adc_data - MID, 1'b0};
    if (adc_data <= MID)     mapped = '0;
    else if (adc_data == FULL) mapped = FULL;
    else if (dbl[DATA_W])    mapped = FULL;
    else                     mapped = dbl[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SMP_IDLE;
      tcnt      <= '0;
      eoc_q     <= 1'b0;
      fault     <= 1'b0;
      upd_valid <= 1'b0;
      upd_duty  <= '0;
    end else begin
      eoc_q     <= adc_eoc;
      upd_valid <= 1'b0;
      unique case (state)
        SMP_IDLE: begin
          tcnt  <= '0;
          state <= SMP_START;
        end
        SMP_START: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == TW'(START_LEN - 1)) state <= SMP_WAIT;
        end
        SMP_WAIT: begin
          if (eoc_rise) begin
            state <= SMP_LATCH;
          end else if (tcnt >= TW'(TMO - 1)) begin
            fault     <= 1'b1;
            upd_valid <= 1'b1;
            upd_duty  <= '0;
            state     <= SMP_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        SMP_LATCH: begin
          upd_duty  <= mapped;
          upd_valid <= 1'b1;
          fault     <= 1'b0;
          state     <= SMP_IDLE;
        end
        default: state <= SMP_IDLE;
      endcase
    end
  end

  // R2: start pulse is at least two cycles long
  assert_start_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_start) |-> $past(adc_start, 2));
  // R3: output enable follows a fresh end-of-conversion edge
  assert_oe_after_eoc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_oe) |-> ($past(adc_eoc) && !$past(adc_eoc, 2)));
  // R3: output enable lasts one cycle
  assert_oe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_oe |=> !adc_oe);
  // R8: a fault rising always comes with a zero duty update
  assert_fault_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> (upd_valid && upd_duty == '0));
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic [DATA_W-1:0] upd_duty,
  output logic              pwm_out,
  output logic [DATA_W-1:0] duty
);
  localparam logic [DATA_W-1:0] TOP = '1;

  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= '0;
      duty <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      if (upd_valid) pend <= upd_duty;
      if (cnt == TOP) duty <= upd_valid ? upd_duty : pend;
    end
  end

  assign pwm_out = (duty == TOP) | (cnt < duty);

  // R7: duty only changes on the wrap
  assert_load_at_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duty) |-> ($past(cnt) == TOP));
  // R5: pulses are left aligned to the period
  assert_left_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> (cnt == '0));
  // R5: pulse ends after duty cycles
  assert_pulse_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_out) |-> (cnt == duty));
endmodule

// File: rtl/servo_pwm.sv
module servo_pwm #(
  parameter int DATA_W      = 8,
  parameter int START_LEN   = 2,
  parameter int CONV_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              adc_start,
  input  logic              adc_eoc,
  output logic              adc_oe,
  input  logic [DATA_W-1:0] adc_data,
  output logic              pwm_out,
  output logic [DATA_W-1:0] duty,
  output logic              fault
);
  logic              upd_valid;
  logic [DATA_W-1:0] upd_duty;

  err_sampler #(
    .DATA_W(DATA_W), .START_LEN(START_LEN), .CONV_CYCLES(CONV_CYCLES)
  ) u_sampler (
    .clk(clk), .rst_n(rst_n),
    .adc_start(adc_start), .adc_eoc(adc_eoc), .adc_oe(adc_oe),
    .adc_data(adc_data),
    .upd_valid(upd_valid), .upd_duty(upd_duty), .fault(fault)
  );

  pwm_core #(.DATA_W(DATA_W)) u_pwm (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_duty(upd_duty),
    .pwm_out(pwm_out), .duty(duty)
  );

  // R2: no start while the converter output is enabled
  assert_no_start_in_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_oe |=> !adc_start);
endmodule

// File: tb/servo_pwm_bench.sv
module servo_pwm_bench;
  localparam int START_LEN = 2;
  localparam int CONV      = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       adc_eoc = 1'b0;
  logic [7:0] adc_data = 8'h00;
  logic       adc_start, adc_oe, pwm_out, fault;
  logic [7:0] duty;

  int tests = 0, fails = 0;
  bit respond = 1'b1;
  int resp_cnt = 0, oe_cnt = 0, start_cnt = 0;
  int bad_start_len = 0, bad_oe = 0, bad_align = 0;
  int cyc = 0, ref_cyc = -1;

  always #5 clk = ~clk;

  servo_pwm #(.DATA_W(8), .START_LEN(START_LEN), .CONV_CYCLES(CONV)) u_servo_pwm (
    .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .adc_eoc(adc_eoc),
    .adc_oe(adc_oe), .adc_data(adc_data), .pwm_out(pwm_out),
    .duty(duty), .fault(fault)
  );

  function automatic int exp_duty(input int code);
    if (code <= 128) return 0;
    if (code == 255) return 255;
    return (2 * (code - 128) > 255) ? 255 : 2 * (code - 128);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure_high(input int d, input string req);
    int hi = 0;
    repeat (256) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    chk(hi == ((d == 255) ? 256 : d), req, hi, (d == 255) ? 256 : d);
  endtask

  // converter model
  initial begin
    forever begin
      @(negedge clk);
      if (adc_start) begin
        adc_eoc = 1'b0;
        while (adc_start) @(negedge clk);
        repeat ($urandom_range(25, 3)) @(negedge clk);
        if (respond) begin
          adc_eoc = 1'b1;
          resp_cnt++;
        end
      end
    end
  end

  // port monitor
  initial begin
    int run = 0;
    logic eoc_p1 = 1'b0, eoc_p2 = 1'b0, st_p = 1'b0;
    logic [7:0] duty_p = 8'h00;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (adc_start) run++;
        else if (run != 0) begin
          if (run != START_LEN) bad_start_len++;
          run = 0;
        end
        if (adc_start && !st_p) start_cnt++;
        if (adc_oe) begin
          oe_cnt++;
          if (!(eoc_p1 && !eoc_p2)) bad_oe++;
        end
        if (pwm_out && ref_cyc < 0) ref_cyc = cyc;
        if (duty != duty_p && ref_cyc >= 0 && ((cyc - ref_cyc) % 256) != 0) bad_align++;
        duty_p = duty;
      end
      eoc_p2 = eoc_p1;
      eoc_p1 = adc_eoc;
      st_p = adc_start;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic run_code(input int code, input string req);
    adc_data = code[7:0];
    repeat (600) @(negedge clk);
    chk(duty == exp_duty(code), req, duty, exp_duty(code));
    measure_high(exp_duty(code), req);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({adc_start, adc_oe, pwm_out, fault} == 4'b0 && duty == 8'h00, "R1",
        {adc_start, adc_oe, pwm_out, fault}, 0);
    rst_n = 1'b1;

    // R4 R5 R6: directed corners
    run_code(0,   "R4 R6 code 00h");
    run_code(128, "R4 code 80h");
    run_code(129, "R4 R5 code 81h");
    run_code(200, "R4 R5 code C8h");
    run_code(254, "R4 R5 code FEh");
    run_code(255, "R4 R6 code FFh");
    run_code(60,  "R4 negative error");
    for (int i = 0; i < 10; i++) run_code($urandom_range(255, 0), "R4 R5 random");

    // R8: timeout
    adc_data = 8'hE0;
    repeat (600) @(negedge clk);
    respond = 1'b0;
    repeat (80) @(negedge clk);
    begin
      int s0 = start_cnt;
      repeat (400) @(negedge clk);
      chk(fault == 1'b1, "R8 fault", fault, 1);
      chk(duty == 8'h00, "R8 duty", duty, 0);
      measure_high(0, "R8 pwm");
      chk(start_cnt - s0 >= 3, "R8 restart", start_cnt - s0, 3);
    end
    // R3: one latch per end-of-conversion edge
    chk(oe_cnt == resp_cnt, "R3 count", oe_cnt, resp_cnt);

    // R9: recovery
    respond = 1'b1;
    adc_data = 8'hA0;
    repeat (600) @(negedge clk);
    chk(fault == 1'b0, "R9 fault clear", fault, 0);
    chk(duty == exp_duty(160), "R9 duty", duty, exp_duty(160));

    chk(bad_start_len == 0, "R2 start length", bad_start_len, 0);
    chk(bad_oe == 0, "R3 oe timing", bad_oe, 0);
    chk(bad_align == 0, "R7 wrap alignment", bad_align, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule